// File: doc/BRIEF.md
# Step/Direction Microstep Position Decoder

This block turns the step and direction lines of an external motion controller into a microstep position. Both lines arrive with no fixed relation to the system clock. The block first passes each line through a chain of synchronizer flops. It then finds active step edges by comparing the synchronized step level with its copy from one cycle earlier. For every active edge it moves a wrapping position counter by one. The direction is the synchronized direction level seen at that same edge.

A configuration input selects which step edges are active. When it is low, only rising edges count. When it is high, every transition counts, whether rising or falling. The outputs are the position index, a strobe that marks each cycle in which the position moved, and the direction of the most recent move. A later stage, such as a current table lookup, uses the index and treats the strobe as its update enable.

Top module: `stepdir_pos_decoder`

## Requirements
- R1: While rst_ni is low, and immediately after it is released, pos_o is 0, step_o is 0 and dir_o is 0.
- R2: With both_edges_i low, each rising transition of step_i moves the position by one step, and a falling transition leaves pos_o unchanged and does not raise step_o.
- R3: With both_edges_i high, each transition of step_i, rising or falling, moves the position by exactly one step.
- R4: A step adds 1 to pos_o when dir_i is 1 and subtracts 1 when dir_i is 0, provided dir_i has been held for at least 4 clock cycles before the step transition and after it.
- R5: pos_o is POS_W bits wide (10 by default) and wraps modulo 2^POS_W in both directions.
- R6: step_o is high in exactly the cycles in which pos_o has just changed, and it is high for one cycle per accepted edge. Each high cycle of step_o matches one change of pos_o. dir_o gives the direction of the latest move (1 means up) and holds that value between steps.
- R7: A step_i transition made between two clock edges first shows on pos_o and step_o after the third rising clock edge that follows it.
- R8: If step_i is already high when reset is released, that level is not counted as a step, in either edge mode.
- R9: The block counts every edge when step_i toggles every clock cycle with both_edges_i low (a step rate of half the clock), and likewise with both_edges_i high.
- R10: A change of both_edges_i takes effect at the next clock edge and keeps the edge history, so changing the mode while step_i holds a level creates no step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Asynchronous step line |
| dir_i | input | 1 | Asynchronous direction line, 1 means count up |
| both_edges_i | input | 1 | 1: every step transition counts; 0: only rising transitions count |
| pos_o | output | POS_W | Microstep position index |
| step_o | output | 1 | High in each cycle in which pos_o has just moved |
| dir_o | output | 1 | Direction of the latest move |

## Verification
A fault in the edge history or in the arming logic after reset shows up as an extra strobe, or a missing one, at the third clock edge after the step transition that caused it. The error then stays in pos_o for good, because nothing ever corrects the position. A counter that moves the wrong way, or wraps wrongly, makes pos_o differ from the arithmetic model once the step sequence has settled, and long sweeps that cross the wrap boundary in both directions reveal it. A strobe that is split or stretched shows as a strobe count that no longer equals the number of active edges.

// File: rtl/stepdir_pkg.sv
package stepdir_pkg;
  localparam int unsigned DEF_POS_W  = 10;
  localparam int unsigned DEF_STAGES = 2;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/stepdir_sync.sv
module stepdir_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/stepdir_edge.sv
module stepdir_edge #(
  parameter int unsigned ARM_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic both_i,
  output logic edge_o
);
  localparam int unsigned ArmW = $clog2(ARM_CYCLES + 1);

  logic            prev_q;
  logic [ArmW-1:0] arm_q;
  logic            armed;
  logic            rise, fall;

  assign armed = (arm_q == ArmW'(ARM_CYCLES));

  // history tracks the level during arming so a level held at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      arm_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      if (!armed) arm_q <= arm_q + 1'b1;
    end
  end

  assign rise   = lvl_i & ~prev_q;
  assign fall   = ~lvl_i & prev_q;
  assign edge_o = armed & (rise | (both_i & fall));
endmodule

// File: rtl/stepdir_pos.sv
module stepdir_pos
  import stepdir_pkg::*;
#(
  parameter int unsigned POS_W = DEF_POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             dir_i,
  output logic [POS_W-1:0] pos_o,
  output logic             step_o,
  output logic             dir_o
);
  logic [POS_W-1:0] pos_q;
  logic             step_q;
  dir_e             dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      step_q <= 1'b0;
      dir_q  <= DIR_DOWN;
    end else begin
      step_q <= evt_i;
      if (evt_i) begin
        dir_q <= dir_e'(dir_i);
        if (dir_i) pos_q <= pos_q + 1'b1;
        else       pos_q <= pos_q - 1'b1;
      end
    end
  end

  assign pos_o  = pos_q;
  assign step_o = step_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/stepdir_pos_decoder.sv
module stepdir_pos_decoder
  import stepdir_pkg::*;
#(
  parameter int unsigned POS_W  = DEF_POS_W,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             both_edges_i,
  output logic [POS_W-1:0] pos_o,
  output logic             step_o,
  output logic             dir_o
);
  localparam int unsigned ArmCycles = STAGES + 1;

  logic [1:0] raw, synced;
  logic       evt;

  assign raw = {dir_i, step_i};

  stepdir_sync #(.STAGES(STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  stepdir_edge #(.ARM_CYCLES(ArmCycles)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (synced[0]),
    .both_i(both_edges_i),
    .edge_o(evt)
  );

  stepdir_pos #(.POS_W(POS_W)) u_pos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .dir_i (synced[1]),
    .pos_o (pos_o),
    .step_o(step_o),
    .dir_o (dir_o)
  );
endmodule

// File: rtl/stepdir_pos_decoder_chk.sv
module stepdir_pos_decoder_chk #(
  parameter int unsigned POS_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [POS_W-1:0] pos_o,
  input logic             step_o,
  input logic             dir_o
);
  logic [2:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  // R6
  pos_moves_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q != 3'd0 && step_o) |-> (pos_o == (dir_o ? $past(pos_o) + 1'b1 : $past(pos_o) - 1'b1)));

  // R6
  pos_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q != 3'd0 && !step_o) |-> $stable(pos_o));

  // R6
  dir_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q != 3'd0 && !step_o) |-> $stable(dir_o));

  // R8
  no_early_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q < 3'd3) |-> !step_o);
endmodule

bind stepdir_pos_decoder stepdir_pos_decoder_chk #(.POS_W(POS_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .pos_o (pos_o),
  .step_o(step_o),
  .dir_o (dir_o)
);

// File: tb/stepdir_pos_decoder_tb.sv
module stepdir_pos_decoder_tb;
  localparam int unsigned POS_W = 10;
  localparam int unsigned MOD   = 1 << POS_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             step_i = 1'b0;
  logic             dir_i = 1'b0;
  logic             both_edges_i = 1'b0;
  logic [POS_W-1:0] pos_o;
  logic             step_o;
  logic             dir_o;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int exp_strobes = 0;
  int exp_pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stepdir_pos_decoder #(.POS_W(POS_W), .STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .dir_i(dir_i),
    .both_edges_i(both_edges_i), .pos_o(pos_o), .step_o(step_o), .dir_o(dir_o)
  );

  always @(negedge clk) if (rst_ni && step_o) strobes++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // flip step_i at a negedge and update the model
  task automatic toggle();
    step_i = ~step_i;
    if (both_edges_i || step_i) begin
      exp_strobes++;
      exp_pos = dir_i ? (exp_pos + 1) % MOD : (exp_pos + MOD - 1) % MOD;
    end
  endtask

  task automatic set_dir(input logic d);
    dir_i = d;
    cyc(4);
  endtask

  task automatic burst(input int n, input int gap, input string req);
    for (int i = 0; i < n; i++) begin
      toggle();
      cyc(gap);
    end
    cyc(5);
    chk({req, " pos"}, int'(pos_o), exp_pos);
    chk({req, " strobes"}, strobes, exp_strobes);
  endtask

  initial begin
    // R1, R8: reset with step_i held high
    step_i = 1'b1;
    cyc(3);
    chk("R1 pos in reset", int'(pos_o), 0);
    chk("R1 step_o in reset", int'(step_o), 0);
    chk("R1 dir_o in reset", int'(dir_o), 0);
    rst_ni = 1'b1;
    cyc(8);
    chk("R8 high at release pos", int'(pos_o), 0);
    chk("R8 high at release strobes", strobes, 0);

    // R2: falling edge ignored in rising mode
    toggle();
    cyc(6);
    chk("R2 falling ignored pos", int'(pos_o), 0);
    chk("R2 falling ignored strobes", strobes, 0);

    // R7, R6: latency and strobe width
    set_dir(1'b1);
    toggle();
    cyc(2);
    chk("R7 unchanged after 2 edges", int'(pos_o), 0);
    chk("R7 no strobe after 2 edges", int'(step_o), 0);
    cyc(1);
    chk("R7 pos after 3 edges", int'(pos_o), 1);
    chk("R6 strobe high", int'(step_o), 1);
    chk("R6 dir_o up", int'(dir_o), 1);
    cyc(1);
    chk("R6 strobe one cycle", int'(step_o), 0);
    cyc(4);

    // R2, R3, R4: sweep mode, direction, rate
    for (int m = 0; m < 2; m++) begin
      both_edges_i = logic'(m);
      cyc(1);
      for (int d = 0; d < 2; d++) begin
        set_dir(logic'(d));
        for (int g = 1; g <= 4; g++) begin
          burst(7 + g, g, m ? "R3 sweep" : "R2 sweep");
          chk("R4 dir_o", int'(dir_o), d);
        end
      end
    end

    // R5, R9: wrap downward at max rate, rising mode
    both_edges_i = 1'b0;
    cyc(1);
    set_dir(1'b0);
    burst(3000, 1, "R5 R9 wrap down rising");
    // R5, R9: wrap upward at one edge per cycle, both-edge mode
    both_edges_i = 1'b1;
    cyc(1);
    set_dir(1'b1);
    burst(2200, 1, "R5 R9 wrap up both");

    // R10: mode change with step level held
    both_edges_i = 1'b0;
    if (step_i) begin toggle(); cyc(6); end
    toggle();
    cyc(6);
    both_edges_i = 1'b1;
    cyc(6);
    chk("R10 mode change no step pos", int'(pos_o), exp_pos);
    chk("R10 mode change no step strobes", strobes, exp_strobes);
    toggle();
    cyc(6);
    chk("R10 falling counts after switch", int'(pos_o), exp_pos);
    both_edges_i = 1'b0;
    cyc(1);
    set_dir(1'b0);
    toggle();
    cyc(6);
    chk("R10 back to rising pos", int'(pos_o), exp_pos);
    chk("R4 dir_o down", int'(dir_o), 0);
    chk("R6 total strobes", strobes, exp_strobes);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule